// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 512K sixteen-bit words. The RAM has two chip enables of opposite polarity, an active-low write strobe, an active-low output enable and one active-low enable per byte lane. The host hands over one word transfer at a time. The block then plays out the pin sequence for that transfer. It counts clock cycles to meet the RAM's minimum access, pulse and cycle times, and it decides when the controller may drive the shared data bus.

The request side is valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The host must hold the request fields stable while `req_valid` is high and `req_ready` is low. `req_ready` is high only while the sequencer is idle, so at most one transfer is in flight. Read data returns on a single-cycle `rsp_valid` pulse with no back-pressure, and the host must take it in that cycle. The data bus is split into output, output-enable and input pins so that the pad ring can build the tristate buffer. All timing values are parameters in clock cycles. The defaults suit a 10 ns clock.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and in every cycle with no transfer in flight, `req_ready` is 1, the RAM is deselected (`sram_ce1_n`=1, `sram_ce2`=0), `sram_we_n`=1, `sram_oe_n`=1, both lane enables are 1, `sram_dq_oe`=0 and `rsp_valid`=0.
- R2: `req_ready` is 1 only in idle cycles. A request is taken on the edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 in the cycle after that edge.
- R3: A read holds `sram_ce1_n`=0, `sram_ce2`=1, `sram_oe_n`=0, `sram_we_n`=1 and the request address for exactly RD_CYC cycles (default 7), starting the cycle after acceptance. Lane enable bit i is the inverse of mask bit i (bit 0 = data[7:0], bit 1 = data[15:8]).
- R4: Read data is taken from `sram_dq_in` in the last of the RD_CYC cycles. `rsp_valid` is 1 for exactly the next cycle, with `rsp_rdata` carrying that data, and lanes whose mask bit is 0 are returned as zero.
- R5: After a read, the RAM stays deselected with the bus released for TURN_CYC cycles (default 3), and `req_ready` returns the cycle after.
- R6: A write starts with one setup cycle (RAM selected, `sram_we_n`=1, bus driven with the write data). It then holds `sram_we_n`=0 for exactly WP_CYC cycles (default 5), followed by hold cycles with `sram_we_n`=1, the RAM still selected and the bus still driven.
- R7: `sram_dq_oe` is 1 only during the setup, pulse and hold cycles of a write. It is never 1 while `sram_oe_n` is 0.
- R8: `sram_we_n` is 0 only while the RAM is selected, and `sram_addr` does not change while `sram_we_n` is 0.
- R9: A write changes only the byte lanes whose mask bit is 1. Its lane enables follow the same encoding as in R3, so a later read returns the merged word.
- R10: The write hold lasts max(1, WC_CYC-1-WP_CYC) cycles (default 1), so one write occupies at least WC_CYC cycles (default 7) from setup to idle.
- R11: A write produces no `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle, request can transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane mask, bit 0 = data[7:0] |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, unmasked lanes zero |
| sram_addr | output | 19 | RAM address pins |
| sram_ce1_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_lane_n | output | 2 | Active-low byte-lane enables, bit 0 = lower |
| sram_dq_out | output | 16 | Data toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_dq_in | input | 16 | Data from the RAM |

## Verification
The hardest case to reach is a write that directly follows a read. This is where a too-early bus drive would clash with the RAM's output. The stimulus keeps `req_valid` high across mixed read and write requests, so the write is accepted on the first idle edge after the read's turnaround. Partial-mask writes followed by full and partial reads of the same word check that lane steering is right both ways. The cycle model then compares every pin in every cycle of these overlapping sequences.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WSET,
    ST_WPULSE,
    ST_WHOLD
  } ctrl_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned hold_cycles(input int unsigned wc, input int unsigned wp);
    return (wc > wp + 2) ? (wc - wp - 1) : 1;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_lanes.sv
module sram_ctrl_lanes #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    sel,
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES-1:0]        lane_n,
  output logic [LANES*LANE_W-1:0] rd_masked
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_n[g] = ~(sel & mask[g]);
    assign rd_masked[g*LANE_W +: LANE_W] = mask[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC   = 7,
  parameter int unsigned TURN_CYC = 3,
  parameter int unsigned WP_CYC   = 5,
  parameter int unsigned HOLD_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic accept,
  output logic capture,
  output logic ready_q,
  output logic sel_q,
  output logic oe_q,
  output logic we_q,
  output logic drv_q
);

  localparam int unsigned MAXD  = max2(max2(RD_CYC, TURN_CYC), max2(WP_CYC, HOLD_CYC));
  localparam int unsigned CNT_W = (MAXD < 2) ? 1 : $clog2(MAXD);

  ctrl_state_e      state_q, state_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          load   = 1'b1;
          if (req_write) begin
            state_d  = ST_WSET;
            load_val = '0;
          end else begin
            state_d  = ST_RD;
            load_val = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_RD: begin
        if (expired) begin
          capture  = 1'b1;
          state_d  = ST_TURN;
          load     = 1'b1;
          load_val = CNT_W'(TURN_CYC - 1);
        end
      end
      ST_TURN: begin
        if (expired) state_d = ST_IDLE;
      end
      ST_WSET: begin
        if (expired) begin
          state_d  = ST_WPULSE;
          load     = 1'b1;
          load_val = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WPULSE: begin
        if (expired) begin
          state_d  = ST_WHOLD;
          load     = 1'b1;
          load_val = CNT_W'(HOLD_CYC - 1);
        end
      end
      ST_WHOLD: begin
        if (expired) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Pin registers are loaded from the next state so they line up with state_q
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b1;
      sel_q   <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= (state_d == ST_IDLE);
      sel_q   <= (state_d != ST_IDLE) && (state_d != ST_TURN);
      oe_q    <= (state_d == ST_RD);
      we_q    <= (state_d == ST_WPULSE);
      drv_q   <= (state_d == ST_WSET) || (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
    end
  end

  // Checker state: length of the current write-strobe run
  int unsigned we_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    we_run_q <= 0;
    else if (we_q) we_run_q <= we_run_q + 1;
    else           we_run_q <= 0;
  end

  assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> !sel_q && !drv_q && !oe_q);
  assert_take_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready_q) |=> !ready_q);
  assert_we_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_q) |-> (we_run_q == WP_CYC));
  assert_drive_before_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_q) |-> $past(drv_q));
  assert_drive_after_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_q) |-> drv_q && sel_q);
  assert_read_not_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> !drv_q);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned RD_CYC   = 7,
  parameter int unsigned TURN_CYC = 3,
  parameter int unsigned WP_CYC   = 5,
  parameter int unsigned WC_CYC   = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic [DATA_W/LANE_W-1:0]   req_be,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic [ADDR_W-1:0]          sram_addr,
  output logic                       sram_ce1_n,
  output logic                       sram_ce2,
  output logic                       sram_we_n,
  output logic                       sram_oe_n,
  output logic [DATA_W/LANE_W-1:0]   sram_lane_n,
  output logic [DATA_W-1:0]          sram_dq_out,
  output logic                       sram_dq_oe,
  input  logic [DATA_W-1:0]          sram_dq_in
);

  localparam int unsigned LANES    = DATA_W / LANE_W;
  localparam int unsigned HOLD_CYC = hold_cycles(WC_CYC, WP_CYC);

  logic              accept, capture;
  logic              ready_q, sel_q, oe_q, we_q, drv_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rd_masked;
  logic [LANES-1:0]  mask_q;
  logic              rsp_q;

  sram_ctrl_seq #(
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .WP_CYC   (WP_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .accept    (accept),
    .capture   (capture),
    .ready_q   (ready_q),
    .sel_q     (sel_q),
    .oe_q      (oe_q),
    .we_q      (we_q),
    .drv_q     (drv_q)
  );

  sram_ctrl_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .sel       (sel_q),
    .mask      (mask_q),
    .dq_in     (sram_dq_in),
    .lane_n    (sram_lane_n),
    .rd_masked (rd_masked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= req_be;
      end
      rsp_q <= capture;
      if (capture) rdata_q <= rd_masked;
    end
  end

  assign req_ready   = ready_q;
  assign rsp_valid   = rsp_q;
  assign rsp_rdata   = rdata_q;
  assign sram_addr   = addr_q;
  assign sram_ce1_n  = ~sel_q;
  assign sram_ce2    = sel_q;
  assign sram_we_n   = ~we_q;
  assign sram_oe_n   = ~oe_q;
  assign sram_dq_out = wdata_q;
  assign sram_dq_oe  = drv_q;

  assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe);
  assert_rsp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_bus_vs_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);
  assert_we_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce1_n && sram_ce2);
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_addr));
  assert_write_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !rsp_valid);

endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;

  localparam int RD   = 7;
  localparam int TURN = 3;
  localparam int WP   = 5;
  localparam int HOLD = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [18:0] sram_addr;
  logic        sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [1:0]  sram_lane_n;
  logic [15:0] sram_dq_out, sram_dq_in;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sram_ctrl u_sram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_lane_n(sram_lane_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  function automatic logic [15:0] blank_word(input logic [18:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  task automatic check(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual %h expected %h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // ---------------- behavioural RAM ----------------
  logic [15:0] ram [int];

  always_comb begin
    logic [15:0] w;
    w = ram.exists(int'(sram_addr)) ? ram[int'(sram_addr)] : blank_word(sram_addr);
    sram_dq_in = 16'hEEEE;
    if (!sram_ce1_n && sram_ce2 && sram_we_n && !sram_oe_n) begin
      if (!sram_lane_n[0]) sram_dq_in[7:0]  = w[7:0];
      if (!sram_lane_n[1]) sram_dq_in[15:8] = w[15:8];
    end
  end

  always @(posedge sram_we_n) begin
    if (rst_n === 1'b1 && sram_ce1_n === 1'b0 && sram_ce2 === 1'b1) begin
      logic [15:0] w;
      check("R6", "bus driven at write end", 32'(sram_dq_oe), 32'd1);
      w = ram.exists(int'(sram_addr)) ? ram[int'(sram_addr)] : blank_word(sram_addr);
      if (!sram_lane_n[0]) w[7:0]  = sram_dq_out[7:0];
      if (!sram_lane_n[1]) w[15:8] = sram_dq_out[15:8];
      ram[int'(sram_addr)] = w;
    end
  end

  always @(negedge sram_we_n) begin
    if (rst_n === 1'b1)
      check("R8", "selected at write start", 32'({sram_ce1_n, sram_ce2}), 32'b01);
  end

  always @(sram_addr) begin
    if (rst_n === 1'b1 && sram_we_n === 1'b0)
      check("R8", "address moved under write strobe", 32'd1, 32'd0);
  end

  // ---------------- cycle reference model ----------------
  typedef struct {
    logic        ready, ce1_n, ce2, we_n, oe_n, dq_oe, rsp;
    logic [1:0]  lane_n;
    logic [18:0] addr;
    logic [15:0] dq_out, rdata;
    bit          wr;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  logic [15:0] shadow [int];
  logic [18:0] last_addr = '0;
  bit          model_ready = 1'b1;

  function automatic exp_t idle_entry(input logic [18:0] a);
    exp_t e;
    e.ready = 1; e.ce1_n = 1; e.ce2 = 0; e.we_n = 1; e.oe_n = 1; e.dq_oe = 0;
    e.rsp = 0; e.lane_n = 2'b11; e.addr = a; e.dq_out = '0; e.rdata = '0;
    e.wr = 0; e.tag = "R1";
    return e;
  endfunction

  always @(posedge clk) begin
    if (rst_n && req_valid && model_ready) begin
      exp_t e;
      logic [15:0] cur;
      cur = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : blank_word(req_addr);
      e = idle_entry(req_addr);
      e.ready = 0;
      if (req_write) begin
        e.wr = 1; e.ce1_n = 0; e.ce2 = 1; e.lane_n = ~req_be;
        e.dq_oe = 1; e.dq_out = req_wdata;
        e.tag = "R6"; expq.push_back(e);
        e.we_n = 0;
        for (int i = 0; i < WP; i++) expq.push_back(e);
        e.we_n = 1; e.tag = "R10";
        for (int i = 0; i < HOLD; i++) expq.push_back(e);
        if (req_be[0]) cur[7:0]  = req_wdata[7:0];
        if (req_be[1]) cur[15:8] = req_wdata[15:8];
        shadow[int'(req_addr)] = cur;
      end else begin
        exp_t t;
        t = e;
        e.ce1_n = 0; e.ce2 = 1; e.oe_n = 0; e.lane_n = ~req_be; e.tag = "R3";
        for (int i = 0; i < RD; i++) expq.push_back(e);
        t.tag = "R5";
        for (int i = 0; i < TURN; i++) begin
          t.rsp = (i == 0);
          t.rdata = {req_be[1] ? cur[15:8] : 8'h00, req_be[0] ? cur[7:0] : 8'h00};
          expq.push_back(t);
        end
      end
      last_addr = req_addr;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      exp_t e;
      if (expq.size() > 0) e = expq.pop_front();
      else e = idle_entry(last_addr);
      model_ready = e.ready;
      check("R2", "req_ready", 32'(req_ready), 32'(e.ready));
      check(e.tag, "sram_ce1_n", 32'(sram_ce1_n), 32'(e.ce1_n));
      check(e.tag, "sram_ce2", 32'(sram_ce2), 32'(e.ce2));
      check(e.tag, "sram_we_n", 32'(sram_we_n), 32'(e.we_n));
      check(e.tag, "sram_oe_n", 32'(sram_oe_n), 32'(e.oe_n));
      check(e.tag, "sram_lane_n", 32'(sram_lane_n), 32'(e.lane_n));
      check(e.tag, "sram_addr", 32'(sram_addr), 32'(e.addr));
      check("R7", "sram_dq_oe", 32'(sram_dq_oe), 32'(e.dq_oe));
      if (e.dq_oe) check("R6", "sram_dq_out", 32'(sram_dq_out), 32'(e.dq_out));
      check(e.wr ? "R11" : "R4", "rsp_valid", 32'(rsp_valid), 32'(e.rsp));
      if (e.rsp) check("R4 R9", "rsp_rdata", 32'(rsp_rdata), 32'(e.rdata));
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input bit wr, input logic [18:0] a, input logic [15:0] d, input logic [1:0] be);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (req_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pause(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "reset req_ready", 32'(req_ready), 32'd1);
    check("R1", "reset enables", 32'({sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n}), 32'b1011);
    check("R1", "reset lanes", 32'(sram_lane_n), 32'b11);
    check("R1", "reset bus", 32'({sram_dq_oe, rsp_valid}), 32'b00);
    @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    pause(3);

    // R6 R9 full write then read back (R3 R4)
    send(1, 19'h00010, 16'h1234, 2'b11);
    pause(2);
    send(0, 19'h00010, 16'h0000, 2'b11);
    pause(12);
    // R9 lower-lane-only write, then full and partial reads
    send(1, 19'h00010, 16'hABCD, 2'b01);
    pause(1);
    send(0, 19'h00010, 16'h0000, 2'b11);
    send(0, 19'h00010, 16'h0000, 2'b10);
    send(0, 19'h00010, 16'h0000, 2'b01);
    pause(2);
    // top address, upper lane only
    send(1, 19'h7FFFF, 16'h5A00, 2'b10);
    send(0, 19'h7FFFF, 16'h0000, 2'b11);
    // untouched word
    send(0, 19'h00000, 16'h0000, 2'b11);
    // empty mask write leaves the word unchanged
    send(1, 19'h00010, 16'hFFFF, 2'b00);
    send(0, 19'h00010, 16'h0000, 2'b11);
    // back-to-back read then write: bus turnaround (R5 R7)
    send(0, 19'h00020, 16'h0000, 2'b11);
    send(1, 19'h00020, 16'hC0DE, 2'b11);
    send(0, 19'h00020, 16'h0000, 2'b11);
    pause(3);
    // mixed random traffic
    for (int i = 0; i < 60; i++) begin
      logic [18:0] a;
      a = 19'h00100 + 19'($urandom % 8);
      send(1'($urandom % 2), a, 16'($urandom), 2'($urandom));
      if ($urandom % 3 == 0) pause(1 + int'($urandom % 4));
    end
    pause(20);
    finish_run();
  end

endmodule